// File: doc/BRIEF.md
# Firmware Write-Enable Control Register

This block holds the eight-bit control byte that decides whether the firmware region of the boot flash may be written. Host software reads it back and writes it through a simple single-cycle port. A separate input says whether every processor is in system management mode. From these the block derives a write-allowed level that the flash controller uses to gate firmware-region writes. It also derives a one-cycle interrupt request to the management-mode handler.

The write-enable bit is updated by the write itself. Only afterwards is the lock bit consulted to request a management interrupt. This leaves a deliberate window in which write enable already reads 1 before the handler can act. The lock bit and the interface lockdown bit are sticky: software can set them but cannot clear them. Only a platform reset clears them. The management-mode-only protect bit restricts writes to moments when all processors are in management mode.

Top module: `fw_wprot_ctrl`

## Requirements
- R1: After platform reset the register reads 0x08: every bit is 0 except the two-bit read configuration field at bits 3:2, which reads 2.
- R2: Bit 0 (write enable) takes the value of bit 0 of every host write, whether 0 or 1.
- R3: Bit 1 (lock enable) is set by a host write carrying a 1 there. A host write of 0 leaves it at 1, and only platform reset clears it.
- R4: Bit 7 (interface lockdown) is set by a host write carrying a 1 there. A host write of 0 leaves it at 1, and only platform reset clears it.
- R5: In the cycle after a host write changes bit 0 from 0 to 1, `smi_req` is high for exactly one cycle if bit 1 is 1 once that write has taken effect. This includes a write that sets bits 0 and 1 together.
- R6: `smi_req` stays low when bit 1 is 0 after the write, and when bit 0 was already 1 before the write.
- R7: When bit 5 (management-mode-only protect) is 1, `fw_wr_allowed` is low while `all_in_smm` is low, whatever bit 0 holds.
- R8: `fw_wr_allowed` equals bit 0 AND (NOT bit 5 OR `all_in_smm`). In particular it is low whenever bit 0 is 0.
- R9: Bits 3:2 (read configuration), bit 4 (top-swap status), bit 5 and bit 6 (boot strap) read back exactly the value of the last host write.
- R10: A host write that sets bit 0 takes effect in the next cycle even when bit 1 is 1. Write enable reads 1 in the same cycle as the interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low platform reset |
| host_wr | input | 1 | Host register write strobe, one cycle per write |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Current register contents |
| all_in_smm | input | 1 | High while every processor is in system management mode |
| fw_wr_allowed | output | 1 | Firmware-region writes permitted |
| smi_req | output | 1 | One-cycle management interrupt request |

## Verification
The assertions assume that `host_wr` and `host_wdata` are stable at each rising edge. They also assume that `all_in_smm` changes only between edges, so that the write-allowed level is judged on a settled input. The bench changes every input on the falling edge and holds `host_wr` low while reset is in force and during the reset-release synchronizer delay. No write is therefore lost or half-applied. `all_in_smm` is held for whole cycles and is toggled only on idle cycles or together with a write.

// File: rtl/fw_wprot_pkg.sv
package fw_wprot_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned B_WREN     = 0;
  localparam int unsigned B_LOCK     = 1;
  localparam int unsigned B_RCFG_LO  = 2;
  localparam int unsigned RCFG_W     = 2;
  localparam int unsigned B_RCFG_HI  = B_RCFG_LO + RCFG_W - 1;
  localparam int unsigned B_TSWAP    = 4;
  localparam int unsigned B_SMMPROT  = 5;
  localparam int unsigned B_BSTRAP   = 6;
  localparam int unsigned B_LOCKDOWN = 7;
  localparam logic [RCFG_W-1:0] RCFG_RST = 2'd2;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/fw_wprot_rst_sync.sv
module fw_wprot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/fw_wprot_field.sv
// Plain read/write field: the value of the last host write.
module fw_wprot_field #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb begin
    d = q;
    if (wr_en) d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= d;
  end

  // R2, R9: a write shows up unchanged in the next cycle
  a_r9_field_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q == $past(wr_val)));
endmodule

// File: rtl/fw_wprot_sticky.sv
// Set-only bit: software can set it, only reset clears it.
module fw_wprot_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  output logic q,
  output logic q_next
);
  always_comb begin
    q_next = q | (wr_en & wr_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_next;
  end

  // R3 and R4: once set, no write clears it
  a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    q |=> q);
  a_r4_sticky_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_val) |=> q);
endmodule

// File: rtl/fw_wprot_smi.sv
// Request pulse issued one cycle after write enable goes 0 -> 1 under lock.
module fw_wprot_smi (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_wren,
  input  logic wren_q,
  input  logic lock_next,
  output logic smi
);
  logic smi_d;

  always_comb begin
    smi_d = wr_en & wr_wren & ~wren_q & lock_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smi <= 1'b0;
    else        smi <= smi_d;
  end

  // R5: the request never lasts more than one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smi |=> !smi);
  // R6: no request without lock
  a_r6_no_smi_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_next |=> !smi);
endmodule

// File: rtl/fw_wprot_gate.sv
module fw_wprot_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wren,
  input  logic smm_prot,
  input  logic all_in_smm,
  output logic allowed
);
  always_comb begin
    allowed = wren & (~smm_prot | all_in_smm);
  end

  // R8: no write permission without write enable
  a_r8_needs_wren: assert property (@(posedge clk) disable iff (!rst_n)
    !wren |-> !allowed);
  // R7: protect bit blocks writes outside management mode
  a_r7_prot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (smm_prot && !all_in_smm) |-> !allowed);
endmodule

// File: rtl/fw_wprot_ctrl.sv
module fw_wprot_ctrl
  import fw_wprot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             all_in_smm,
  output logic             fw_wr_allowed,
  output logic             smi_req
);
  logic              rst_n_s;
  logic              wren_q;
  logic              lock_q, lock_nx;
  logic [RCFG_W-1:0] rcfg_q;
  logic              tswap_q, prot_q, bstrap_q;
  logic              lockdn_q, lockdn_nx;

  fw_wprot_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n_a(rst_n), .rst_n_s(rst_n_s));

  fw_wprot_field #(.W(1), .RST(1'b0)) u_wren (
    .clk(clk), .rst_n(rst_n_s), .wr_en(host_wr),
    .wr_val(host_wdata[B_WREN]), .q(wren_q));

  fw_wprot_sticky u_lock (
    .clk(clk), .rst_n(rst_n_s), .wr_en(host_wr),
    .wr_val(host_wdata[B_LOCK]), .q(lock_q), .q_next(lock_nx));

  fw_wprot_field #(.W(RCFG_W), .RST(RCFG_RST)) u_rcfg (
    .clk(clk), .rst_n(rst_n_s), .wr_en(host_wr),
    .wr_val(host_wdata[B_RCFG_HI:B_RCFG_LO]), .q(rcfg_q));

  fw_wprot_field #(.W(1), .RST(1'b0)) u_tswap (
    .clk(clk), .rst_n(rst_n_s), .wr_en(host_wr),
    .wr_val(host_wdata[B_TSWAP]), .q(tswap_q));

  fw_wprot_field #(.W(1), .RST(1'b0)) u_prot (
    .clk(clk), .rst_n(rst_n_s), .wr_en(host_wr),
    .wr_val(host_wdata[B_SMMPROT]), .q(prot_q));

  fw_wprot_field #(.W(1), .RST(1'b0)) u_bstrap (
    .clk(clk), .rst_n(rst_n_s), .wr_en(host_wr),
    .wr_val(host_wdata[B_BSTRAP]), .q(bstrap_q));

  fw_wprot_sticky u_lockdn (
    .clk(clk), .rst_n(rst_n_s), .wr_en(host_wr),
    .wr_val(host_wdata[B_LOCKDOWN]), .q(lockdn_q), .q_next(lockdn_nx));

  fw_wprot_smi u_smi (
    .clk(clk), .rst_n(rst_n_s), .wr_en(host_wr),
    .wr_wren(host_wdata[B_WREN]), .wren_q(wren_q),
    .lock_next(lock_nx), .smi(smi_req));

  fw_wprot_gate u_gate (
    .clk(clk), .rst_n(rst_n_s), .wren(wren_q), .smm_prot(prot_q),
    .all_in_smm(all_in_smm), .allowed(fw_wr_allowed));

  always_comb begin
    host_rdata = '0;
    host_rdata[B_WREN]              = wren_q;
    host_rdata[B_LOCK]              = lock_q;
    host_rdata[B_RCFG_HI:B_RCFG_LO] = rcfg_q;
    host_rdata[B_TSWAP]             = tswap_q;
    host_rdata[B_SMMPROT]           = prot_q;
    host_rdata[B_BSTRAP]            = bstrap_q;
    host_rdata[B_LOCKDOWN]          = lockdn_q;
  end

  // R5: setting write enable under lock yields a request next cycle
  a_r5_smi_after_set: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_wr && host_wdata[B_WREN] && !host_rdata[B_WREN] && host_rdata[B_LOCK])
    |=> smi_req);
  // R10: write enable is already 1 while the request is raised
  a_r10_race_window: assert property (@(posedge clk) disable iff (!rst_n_s)
    smi_req |-> host_rdata[B_WREN]);
  // R6: re-writing an already set write enable raises nothing
  a_r6_no_smi_when_set: assert property (@(posedge clk) disable iff (!rst_n_s)
    host_rdata[B_WREN] |=> !smi_req);
endmodule

// File: tb/fw_wprot_ctrl_bench.sv
module fw_wprot_ctrl_bench;
  typedef struct {
    logic [7:0] rd;
    logic       smi;
    logic       alw;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic       all_in_smm = 1'b0;
  logic [7:0] host_rdata;
  logic       fw_wr_allowed;
  logic       smi_req;

  int n_chk = 0;
  int n_bad = 0;
  exp_t q_exp[$];
  logic [7:0] mdl;

  always #10 clk = ~clk;

  fw_wprot_ctrl u_fw_wprot_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .all_in_smm(all_in_smm),
    .fw_wr_allowed(fw_wr_allowed), .smi_req(smi_req));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected result
  task automatic op(input logic wr, input logic [7:0] d, input logic smm, input string tag);
    exp_t e;
    logic smi;
    @(negedge clk);
    host_wr = wr; host_wdata = d; all_in_smm = smm;
    smi = 1'b0;
    if (wr) begin
      smi = d[0] & ~mdl[0] & (mdl[1] | d[1]);
      mdl = {mdl[7] | d[7], d[6:2], mdl[1] | d[1], d[0]};
    end
    e.rd = mdl; e.smi = smi; e.alw = mdl[0] & (~mdl[5] | smm); e.tag = tag;
    q_exp.push_back(e);
  endtask

  // monitor: compare a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    if (q_exp.size() > 0) begin
      exp_t e;
      e = q_exp.pop_front();
      chk({e.tag, " rdata"}, host_rdata, e.rd);
      chk({e.tag, " smi_req"}, {7'd0, smi_req}, {7'd0, e.smi});
      chk({e.tag, " fw_wr_allowed"}, {7'd0, fw_wr_allowed}, {7'd0, e.alw});
    end
  end

  task automatic do_reset();
    @(negedge clk);
    host_wr = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset value", host_rdata, 8'h08);
    chk("R1 reset smi", {7'd0, smi_req}, 8'h00);
    mdl = 8'h08;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    mdl = 8'h08;
    do_reset();
    op(1, 8'h09, 0, "R2 R6 R8 set wren unlocked");
    op(0, 8'h00, 0, "R6 idle");
    op(1, 8'h08, 0, "R2 R8 clear wren");
    op(1, 8'h5C, 0, "R9 plain fields a");
    op(1, 8'h20, 0, "R9 plain fields b");
    op(1, 8'h21, 0, "R7 prot outside smm");
    op(0, 8'h00, 1, "R7 R8 prot in smm");
    op(0, 8'h00, 0, "R7 smm left");
    op(1, 8'h0A, 0, "R3 set lock");
    op(1, 8'h08, 0, "R3 lock write 0 ignored");
    op(1, 8'h0B, 0, "R5 R10 set wren locked");
    op(0, 8'h00, 0, "R5 pulse ends");
    op(1, 8'h0B, 0, "R6 wren already set");
    op(1, 8'h0A, 0, "R2 handler clears wren");
    op(1, 8'h0B, 1, "R5 R10 second set");
    op(1, 8'h88, 0, "R4 set lockdown");
    op(1, 8'h00, 0, "R3 R4 write zero");
    op(0, 8'h00, 0, "R4 idle");
    repeat (3) @(negedge clk);
    do_reset();
    op(1, 8'h09, 0, "R3 R6 lock cleared by reset");
    op(1, 8'h08, 0, "R2 clear");
    op(1, 8'h0B, 0, "R5 set wren and lock together");
    op(0, 8'h00, 0, "R5 idle");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule